// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Interrupts

This block gives a processor control of 32 general-purpose pins through a small word-wide register bus. Software writes an output value and an output-enable (direction) per pin. It can also flip individual output bits through dedicated set and clear addresses, which avoids read-modify-write races between threads. The pins are read back through a two-stage synchronizer. Two further per-pin words, pull enable and pull select, are only stored and driven out to the pad ring.

Every pin can raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. The choice is made by three per-pin configuration words: sense kind, invert, and any-edge. Edge events are latched until software clears them through a write-one-to-clear address. Level events follow the live pin. A per-pin enable gates event generation, and a per-pin mask keeps pending pins off the single combined interrupt line.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every writable register reads 0, the interrupt status reads 0, and `pin_o`, `pin_oe_o`, `pull_en_o`, `pull_sel_o` and `irq_o` are 0.
- R2: A write to byte offset 0x00 loads the output word, which is driven on `pin_o` and read back at 0x00. A write to 0x08 loads the direction word, which is driven on `pin_oe_o`, where bit = 1 means the pin is an output.
- R3: A write to 0x10 sets every output bit whose written bit is 1 and leaves all other output bits unchanged.
- R4: A write to 0x14 clears every output bit whose written bit is 1 and leaves all other output bits unchanged.
- R5: Offset 0x04 returns `pin_i` delayed by two clock edges. Writes to 0x04 change nothing.
- R6: Offsets 0x18 and 0x1C hold plain words that are driven on `pull_en_o` and `pull_sel_o` and read back unchanged.
- R7: With sense bit (0x34) = 0, a pin senses edges and its status bit at 0x24 is latched. The any-edge bit (0x38) = 1 triggers on either edge. Otherwise the invert bit (0x3C) selects the edge: 0 for rising, 1 for falling.
- R8: With sense bit = 1, a pin senses levels: invert = 0 is active-high and invert = 1 is active-low. Its status follows the synchronized level and is not latched, so a clear write leaves it set while the level persists.
- R9: A write to 0x30 clears the latched edge status bits written as 1 and leaves bits written as 0 alone. An edge arriving in the same cycle as the clear of its bit leaves the bit set.
- R10: A pin whose enable bit (0x20) is 0 raises no status.
- R11: `irq_o` is the OR of status bits whose mask bit (0x2C) is 0. A mask bit of 1 hides that pin from `irq_o` but not from the status register.
- R12: Offsets 0x0C, 0x28, 0x40, 0x44 and any offset at or above 0x48 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Byte offset of the register access |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pin_i | input | 32 | Pin input levels |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables (1 = drive) |
| pull_en_o | output | 32 | Stored pull-enable word |
| pull_sel_o | output | 32 | Stored pull-select word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the edge that ends its write cycle. Reads are combinational, so the bench samples them one nanosecond after it drives the address at the falling edge. A change on `pin_i` shows at 0x04 after two rising edges. A level status changes after two edges, and a latched edge status after three. The bench therefore waits at least four whole cycles after each pin stimulus before it samples status or `irq_o`. The same-cycle edge-versus-clear case is timed to the edge count: the pin changes two falling edges before the clear strobe is raised.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_DOUT  = 7'h00,
    A_DIN   = 7'h04,
    A_DIR   = 7'h08,
    A_SET   = 7'h10,
    A_CLR   = 7'h14,
    A_PEN   = 7'h18,
    A_PSEL  = 7'h1C,
    A_IEN   = 7'h20,
    A_ISTAT = 7'h24,
    A_IMASK = 7'h2C,
    A_IACK  = 7'h30,
    A_ISENS = 7'h34,
    A_IANY  = 7'h38,
    A_IINV  = 7'h3C
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,   // synchronized pin
  input  logic en_i,
  input  logic sens_i,  // 1: level, 0: edge
  input  logic any_i,
  input  logic inv_i,
  input  logic ack_i,
  output logic stat_o
);
  logic prev_q, lat_q;
  logic rise, fall, edge_hit, lvl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise     = lvl_i & ~prev_q;
  assign fall     = ~lvl_i & prev_q;
  assign edge_hit = en_i & ~sens_i & (any_i ? (rise | fall) : (inv_i ? fall : rise));
  assign lvl_hit  = en_i & sens_i & (lvl_i ^ inv_i);

  // new edge beats a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= 1'b0;
    else         lat_q <= edge_hit | (lat_q & ~ack_i);
  end

  assign stat_o = lat_q | lvl_hit;

  AST_EDGE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q && !ack_i |=> lat_q); // R9
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_hit && ack_i |=> lat_q); // R9
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !lat_q |=> !lat_q); // R10
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !en_i |=> !lat_q); // R9
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     pin_i,
  output logic [DW-1:0]     pin_o,
  output logic [DW-1:0]     pin_oe_o,
  output logic [DW-1:0]     pull_en_o,
  output logic [DW-1:0]     pull_sel_o,
  output logic              irq_o
);
  logic [DW-1:0] dout_q, dir_q, pen_q, psel_q;
  logic [DW-1:0] ien_q, imask_q, isens_q, iany_q, iinv_q;
  logic [DW-1:0] din_s, stat, ack_vec;

  logic w_dout, w_dir, w_set, w_clr, w_pen, w_psel;
  logic w_ien, w_imask, w_ack, w_sens, w_any, w_inv;

  assign w_dout  = we_i && addr_i == A_DOUT;
  assign w_dir   = we_i && addr_i == A_DIR;
  assign w_set   = we_i && addr_i == A_SET;
  assign w_clr   = we_i && addr_i == A_CLR;
  assign w_pen   = we_i && addr_i == A_PEN;
  assign w_psel  = we_i && addr_i == A_PSEL;
  assign w_ien   = we_i && addr_i == A_IEN;
  assign w_imask = we_i && addr_i == A_IMASK;
  assign w_ack   = we_i && addr_i == A_IACK;
  assign w_sens  = we_i && addr_i == A_ISENS;
  assign w_any   = we_i && addr_i == A_IANY;
  assign w_inv   = we_i && addr_i == A_IINV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      dir_q   <= '0;
      pen_q   <= '0;
      psel_q  <= '0;
      ien_q   <= '0;
      imask_q <= '0;
      isens_q <= '0;
      iany_q  <= '0;
      iinv_q  <= '0;
    end else begin
      if (w_dout)      dout_q <= wdata_i;
      else if (w_set)  dout_q <= dout_q | wdata_i;
      else if (w_clr)  dout_q <= dout_q & ~wdata_i;
      if (w_dir)   dir_q   <= wdata_i;
      if (w_pen)   pen_q   <= wdata_i;
      if (w_psel)  psel_q  <= wdata_i;
      if (w_ien)   ien_q   <= wdata_i;
      if (w_imask) imask_q <= wdata_i;
      if (w_sens)  isens_q <= wdata_i;
      if (w_any)   iany_q  <= wdata_i;
      if (w_inv)   iinv_q  <= wdata_i;
    end
  end

  gpio_sync #(.W(DW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (din_s)
  );

  assign ack_vec = w_ack ? wdata_i : '0;

  for (genvar i = 0; i < DW; i++) begin : g_pin
    gpio_trig u_trig (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (din_s[i]),
      .en_i  (ien_q[i]),
      .sens_i(isens_q[i]),
      .any_i (iany_q[i]),
      .inv_i (iinv_q[i]),
      .ack_i (ack_vec[i]),
      .stat_o(stat[i])
    );
  end

  always_comb begin
    case (addr_i)
      A_DOUT:  rdata_o = dout_q;
      A_DIN:   rdata_o = din_s;
      A_DIR:   rdata_o = dir_q;
      A_PEN:   rdata_o = pen_q;
      A_PSEL:  rdata_o = psel_q;
      A_IEN:   rdata_o = ien_q;
      A_ISTAT: rdata_o = stat;
      A_IMASK: rdata_o = imask_q;
      A_ISENS: rdata_o = isens_q;
      A_IANY:  rdata_o = iany_q;
      A_IINV:  rdata_o = iinv_q;
      default: rdata_o = '0;
    endcase
  end

  assign pin_o      = dout_q;
  assign pin_oe_o   = dir_q;
  assign pull_en_o  = pen_q;
  assign pull_sel_o = psel_q;
  assign irq_o      = |(stat & ~imask_q);

  AST_SET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_set |=> (dout_q & $past(wdata_i)) == $past(wdata_i)); // R3
  AST_SET_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_set |=> ((dout_q ^ $past(dout_q)) & ~$past(wdata_i)) == '0); // R3
  AST_CLR_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_clr |=> (dout_q & $past(wdata_i)) == '0); // R4
  AST_CLR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_clr |=> ((dout_q ^ $past(dout_q)) & ~$past(wdata_i)) == '0); // R4
  AST_ALL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&imask_q) |-> !irq_o); // R11
  AST_NO_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat == '0 |-> !irq_o); // R11
  AST_PIN_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) |-> din_s == $past(pin_i, 2)); // R5
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, pin_i, pin_o, pin_oe_o, pull_en_o, pull_sel_o;
  logic        irq_o;
  int n_run = 0, n_fail = 0;
  logic [31:0] rv;

  initial pin_i = '0;
  always #5 clk_i = ~clk_i;

  gpio_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .pull_en_o(pull_en_o), .pull_sel_o(pull_sel_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  // call at a falling edge: combinational read
  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pa [4];
    logic [31:0] pb [4];
    logic [31:0] exp_s;
    logic [6:0] regs [10];
    logic [6:0] holes [6];
    pa[0] = 32'h0000_0000; pb[0] = 32'hFFFF_FFFF;
    pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0000;
    pa[2] = 32'hA5C3_0F96; pb[2] = 32'h5A3C_F069;
    pa[3] = 32'h1234_5678; pb[3] = 32'h1234_F00F;
    regs[0] = 7'h00; regs[1] = 7'h08; regs[2] = 7'h18; regs[3] = 7'h1C; regs[4] = 7'h20;
    regs[5] = 7'h24; regs[6] = 7'h2C; regs[7] = 7'h34; regs[8] = 7'h38; regs[9] = 7'h3C;
    holes[0] = 7'h0C; holes[1] = 7'h28; holes[2] = 7'h40; holes[3] = 7'h44;
    holes[4] = 7'h48; holes[5] = 7'h7C;

    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      rd(regs[i], rv); chk("R1 reg", rv, 32'h0);
    end
    chk("R1 outputs", pin_o | pin_oe_o | pull_en_o | pull_sel_o, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);

    // R2 output word and direction
    wr(7'h00, 32'hA5A5_3C3C);
    rd(7'h00, rv); chk("R2 dout read", rv, 32'hA5A5_3C3C);
    chk("R2 pin_o", pin_o, 32'hA5A5_3C3C);
    wr(7'h08, 32'hF0F0_00FF);
    rd(7'h08, rv); chk("R2 dir read", rv, 32'hF0F0_00FF);
    chk("R2 pin_oe_o", pin_oe_o, 32'hF0F0_00FF);

    // R3 set, R4 clear
    wr(7'h10, 32'h0F0F_0001);
    chk("R3 set", pin_o, 32'hA5A5_3C3C | 32'h0F0F_0001);
    wr(7'h14, 32'h0000_FF0F);
    chk("R4 clear", pin_o, (32'hA5A5_3C3C | 32'h0F0F_0001) & ~32'h0000_FF0F);
    rd(7'h10, rv); chk("R12 set addr reads 0", rv, 32'h0);

    // R5 input sync latency
    @(negedge clk_i);
    pin_i = 32'h1234_5678;
    @(negedge clk_i);
    rd(7'h04, rv); chk("R5 one edge", rv, 32'h0);
    @(negedge clk_i);
    rd(7'h04, rv); chk("R5 two edges", rv, 32'h1234_5678);
    wr(7'h04, 32'hFFFF_FFFF);
    rd(7'h04, rv); chk("R5 write ignored", rv, 32'h1234_5678);

    // R6 pull storage
    wr(7'h18, 32'hDEAD_BEEF);
    wr(7'h1C, 32'h0BAD_F00D);
    rd(7'h18, rv); chk("R6 pen read", rv, 32'hDEAD_BEEF);
    rd(7'h1C, rv); chk("R6 psel read", rv, 32'h0BAD_F00D);
    chk("R6 pull_en_o", pull_en_o, 32'hDEAD_BEEF);
    chk("R6 pull_sel_o", pull_sel_o, 32'h0BAD_F00D);

    // R12 holes
    for (int i = 0; i < 6; i++) begin
      wr(holes[i], 32'hFFFF_FFFF);
      rd(holes[i], rv); chk("R12 hole read", rv, 32'h0);
    end
    chk("R12 no side effect dout", pin_o, (32'hA5A5_3C3C | 32'h0F0F_0001) & ~32'h0000_FF0F);
    chk("R12 no side effect dir", pin_oe_o, 32'hF0F0_00FF);

    // R7 / R8 sweep: modes 0 rise,1 fall,2 any,3 high,4 low
    for (int m = 0; m < 5; m++) begin
      for (int p = 0; p < 4; p++) begin
        wr(7'h20, 32'h0);
        @(negedge clk_i); pin_i = pa[p];
        idle(4);
        wr(7'h34, (m >= 3) ? 32'hFFFF_FFFF : 32'h0);
        wr(7'h38, (m == 2) ? 32'hFFFF_FFFF : 32'h0);
        wr(7'h3C, (m == 1 || m == 4) ? 32'hFFFF_FFFF : 32'h0);
        wr(7'h30, 32'hFFFF_FFFF);
        wr(7'h20, 32'hFFFF_FFFF);
        rd(7'h24, rv);
        exp_s = (m == 3) ? pa[p] : (m == 4) ? ~pa[p] : 32'h0;
        chk((m >= 3) ? "R8 level before" : "R7 edge before", rv, exp_s);
        @(negedge clk_i); pin_i = pb[p];
        idle(4);
        case (m)
          0: exp_s = pb[p] & ~pa[p];
          1: exp_s = pa[p] & ~pb[p];
          2: exp_s = pa[p] ^ pb[p];
          3: exp_s = pb[p];
          default: exp_s = ~pb[p];
        endcase
        rd(7'h24, rv);
        chk((m >= 3) ? "R8 level after" : "R7 edge after", rv, exp_s);
        chk("R11 irq unmasked", {31'h0, irq_o}, {31'h0, exp_s != 32'h0});
        if (m >= 3) begin
          wr(7'h30, 32'hFFFF_FFFF);
          rd(7'h24, rv); chk("R8 clear no lasting effect", rv, exp_s);
        end
      end
    end

    // R10 enable subset, rising mode
    wr(7'h20, 32'h0);
    @(negedge clk_i); pin_i = 32'h0;
    idle(4);
    wr(7'h34, 32'h0); wr(7'h38, 32'h0); wr(7'h3C, 32'h0);
    wr(7'h30, 32'hFFFF_FFFF);
    wr(7'h20, 32'h0000_FFFF);
    @(negedge clk_i); pin_i = 32'hFFFF_FFFF;
    idle(4);
    rd(7'h24, rv); chk("R10 disabled pins quiet", rv, 32'h0000_FFFF);

    // R11 mask
    wr(7'h2C, 32'h0000_FFFF);
    chk("R11 fully masked", {31'h0, irq_o}, 32'h0);
    rd(7'h24, rv); chk("R11 status unaffected by mask", rv, 32'h0000_FFFF);
    wr(7'h2C, 32'hFFFF_00FF);
    chk("R11 partly masked", {31'h0, irq_o}, 32'h1);
    wr(7'h2C, 32'h0);

    // R9 selective clear
    wr(7'h30, 32'h0000_00F0);
    rd(7'h24, rv); chk("R9 selective clear", rv, 32'h0000_FF0F);

    // R9 edge wins over same-cycle clear
    wr(7'h20, 32'h0);
    @(negedge clk_i); pin_i = 32'h0;
    idle(4);
    wr(7'h30, 32'hFFFF_FFFF);
    wr(7'h20, 32'hFFFF_FFFF);
    @(negedge clk_i); pin_i = 32'h0000_0002;
    idle(4);
    rd(7'h24, rv); chk("R9 prelatched", rv, 32'h0000_0002);
    pin_i = 32'h0000_0003;
    @(negedge clk_i);
    wr(7'h30, 32'h0000_0003);
    rd(7'h24, rv); chk("R9 edge beats clear", rv, 32'h0000_0001);
    wr(7'h30, 32'h0000_0001);
    rd(7'h24, rv); chk("R9 later clear", rv, 32'h0);
    chk("R11 idle irq", {31'h0, irq_o}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule